// File: doc/BRIEF.md
# PWM Channel Waveform Generator

This block produces the waveform of a single pulse-width-modulated channel. It takes a tick that is already divided down elsewhere and divides it again with its own prescaler. It counts prescaled steps through a programmable period. For the first part of each period it drives the pad at a programmable active level, and for the rest it drives the opposite level. When the channel is switched off, it releases the pad.

Software programs the block through a write strobe, a two-bit address and a 32-bit data word. Address 0 holds the control word, with the prescaler and the active level. Address 1 holds the period word, with the period length and the active length. Address 2 holds an enable word that many channels share, and this instance reads only its own bit. A new value takes effect on the very next cycle. The running period is abandoned and the counters start again from zero.

Top module: `pwm_wavegen`

## Requirements
- R1: Control word bits 7:0 hold a prescale value k. A prescaled step happens after every k+1 cycles with `tickIn` high, and cycles with `tickIn` low advance nothing.
- R2: Control word bit 8 selects the active level. A 1 drives `padOut` high during the active phase and low otherwise. A 0 inverts both.
- R3: Period word bits 31:16 hold N-1 for a period of N prescaled steps. The step counter wraps from N-1 to 0.
- R4: Period word bits 15:0 hold the active length A in prescaled steps. The output is at the active level while the step count within the period is below A.
- R5: Bit CHAN_IDX of the enable word (address 2) enables the channel. While it is clear, `padOe` is 0, `padOut` is 0 and the counters are held at zero, and the other bits of that word have no effect.
- R6: A write to the control word or the period word takes effect on the next cycle, and it restarts the prescaler and the step counter at zero, even in the middle of a period.
- R7: If A is greater than or equal to N, the output stays at the active level for the whole period.
- R8: If A is 0, the output stays at the inactive level.
- R9: A write to address 3 changes neither the configuration nor the counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | Divided clock tick, one cycle wide |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 control, 1 period, 2 enable |
| wrData | input | 32 | Register write data |
| padOut | output | 1 | Pad value |
| padOe | output | 1 | Pad output enable; 0 means high impedance |

## Verification
A corrupted prescaler or step counter shows at the pad as a wrong edge position, usually within one period. A bad wrap or a missed clear on a write moves every later edge, so it shows at the first transition after the fault. A wrong active compare or a swapped level shows on the very cycle the count crosses A. The enable path shows on the cycle after the enable write. Comparing the pad against a behavioural model on every cycle therefore catches most faults within a few periods of the disturbing stimulus.

// File: rtl/pwm_wavegen_pkg.sv
package pwm_wavegen_pkg;
  localparam int PRESC_W = 8;
  localparam int PER_W   = 16;

  typedef struct packed {
    logic [PRESC_W-1:0] prescK;
    logic               level;
    logic [PER_W-1:0]   entire;
    logic [PER_W-1:0]   activeCnt;
    logic               enable;
  } pwmCfg_t;

  typedef struct packed {
    logic clear;
    logic step;
  } pwmStrb_t;
endpackage

// File: rtl/pwm_wavegen_ctrl.sv
module pwm_wavegen_ctrl
  import pwm_wavegen_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int CHAN_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output pwmCfg_t           cfg,
  output pwmStrb_t          strb
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_EN     = ADDR_W'(2);
  localparam int LEVEL_BIT = PRESC_W;
  localparam int ENT_LSB   = DATA_W - PER_W;

  logic wrCtrl, wrPeriod, wrEnable;
  assign wrCtrl   = wrEn && (wrAddr == ADDR_CTRL);
  assign wrPeriod = wrEn && (wrAddr == ADDR_PERIOD);
  assign wrEnable = wrEn && (wrAddr == ADDR_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wrCtrl) begin
        cfg.prescK <= wrData[PRESC_W-1:0];
        cfg.level  <= wrData[LEVEL_BIT];
      end
      if (wrPeriod) begin
        cfg.entire    <= wrData[DATA_W-1:ENT_LSB];
        cfg.activeCnt <= wrData[PER_W-1:0];
      end
      if (wrEnable) begin
        cfg.enable <= wrData[CHAN_IDX];
      end
    end
  end

  always_comb begin
    strb.clear = wrCtrl || wrPeriod || !cfg.enable;
    strb.step  = tickIn;
  end
endmodule

// File: rtl/pwm_wavegen_dp.sv
module pwm_wavegen_dp
  import pwm_wavegen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pwmCfg_t  cfg,
  input  pwmStrb_t strb,
  output logic     padOut,
  output logic     padOe
);
  logic [PRESC_W-1:0] preCnt;
  logic [PER_W-1:0]   stepCnt;
  logic               preWrap;
  logic               inActive;

  assign preWrap = (preCnt == cfg.prescK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt  <= '0;
      stepCnt <= '0;
    end else if (strb.clear) begin
      preCnt  <= '0;
      stepCnt <= '0;
    end else if (strb.step) begin
      if (preWrap) begin
        preCnt  <= '0;
        stepCnt <= (stepCnt == cfg.entire) ? '0 : stepCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign inActive = (stepCnt < cfg.activeCnt);

  always_comb begin
    padOe  = cfg.enable;
    padOut = cfg.enable && (inActive ? cfg.level : !cfg.level);
  end

  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    preCnt <= cfg.prescK);

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stepCnt <= cfg.entire);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> (preCnt == '0 && stepCnt == '0));

  assert_full_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (padOe && cfg.activeCnt > cfg.entire) |-> (padOut == cfg.level));

  assert_zero_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (padOe && cfg.activeCnt == '0) |-> (padOut == !cfg.level));
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
  import pwm_wavegen_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int CHAN_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              padOut,
  output logic              padOe
);
  pwmCfg_t  cfg;
  pwmStrb_t strb;

  pwm_wavegen_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAN_IDX(CHAN_IDX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickIn(tickIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .cfg(cfg), .strb(strb)
  );

  pwm_wavegen_dp u_dp (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .strb(strb),
    .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: tb/pwm_wavegen_bench.sv
module pwm_wavegen_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tickIn = 0;
  logic        wrEn = 0;
  logic [1:0]  wrAddr = 0;
  logic [31:0] wrData = 0;
  logic        padOut, padOe;

  int checks = 0, fails = 0, cyc = 0;
  string curReq = "R5";

  int mPre = 0, mCnt = 0, mK = 0, mLvl = 0, mEnt = 0, mAct = 0, mEn = 0;

  always #10 clk = ~clk;

  pwm_wavegen u_pwm_wavegen (
    .clk(clk), .rst_n(rst_n), .tickIn(tickIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .padOut(padOut), .padOe(padOe)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPre = 0; mCnt = 0; mK = 0; mLvl = 0; mEnt = 0; mAct = 0; mEn = 0;
    end else begin
      if ((wrEn && (wrAddr == 0 || wrAddr == 1)) || mEn == 0) begin
        mPre = 0; mCnt = 0;
      end else if (tickIn) begin
        if (mPre == mK) begin
          mPre = 0;
          mCnt = (mCnt == mEnt) ? 0 : mCnt + 1;
        end else mPre = mPre + 1;
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: begin mK = int'(wrData[7:0]); mLvl = int'(wrData[8]); end
          2'd1: begin mEnt = int'(wrData[31:16]); mAct = int'(wrData[15:0]); end
          2'd2: mEn = int'(wrData[0]);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int expOe, expOut;
    cyc++;
    expOe  = mEn;
    expOut = (mEn != 0) ? ((mCnt < mAct) ? mLvl : 1 - mLvl) : 0;
    checks++;
    if (padOe !== expOe[0] || padOut !== expOut[0]) begin
      fails++;
      $display("FAIL %s cycle %0d: actual oe=%b out=%b expected oe=%0d out=%0d",
               curReq, cyc, padOe, padOut, expOe, expOut);
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; wrData = 0;
  endtask

  task automatic run(input int n, input int tickEvery);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickIn = (tickEvery > 0) && (i % tickEvery == 0);
    end
    @(negedge clk);
    tickIn = 0;
  endtask

  initial begin
    curReq = "R5 reset";
    repeat (3) @(negedge clk);
    rst_n = 1;
    curReq = "R2 R3 R4 basic";
    wr(2'd0, 32'h0000_0100);            // k=0, active high
    wr(2'd1, {16'd4, 16'd2});           // N=5, A=2
    curReq = "R5 enable";
    wr(2'd2, 32'h0000_0001);
    curReq = "R2 R3 R4 basic";
    run(40, 1);
    curReq = "R1 prescale";
    wr(2'd0, 32'h0000_0102);            // k=2
    run(60, 2);
    curReq = "R1 tick low";
    run(20, 0);
    curReq = "R2 inverted level";
    wr(2'd0, 32'h0000_0001);
    run(40, 1);
    curReq = "R7 active above period";
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, {16'd4, 16'd9});
    run(30, 1);
    curReq = "R7 active equals period";
    wr(2'd1, {16'd4, 16'd5});
    run(30, 1);
    curReq = "R8 zero active";
    wr(2'd1, {16'd6, 16'd0});
    run(30, 1);
    curReq = "R6 mid-period write";
    wr(2'd1, {16'd7, 16'd3});
    run(5, 1);
    wr(2'd1, {16'd3, 16'd1});
    run(3, 1);
    wr(2'd0, 32'h0000_0101);
    run(25, 1);
    curReq = "R9 unmapped address";
    wr(2'd3, 32'hFFFF_FFFF);
    run(25, 1);
    curReq = "R5 other enable bits only";
    wr(2'd2, 32'hFFFF_FFFE);
    run(15, 1);
    curReq = "R5 re-enable with other bits";
    wr(2'd2, 32'h8000_0003);
    run(30, 3);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule